// File: doc/BRIEF.md
# Transmit Loss-of-Carrier Monitor

This block confirms that an external transceiver echoes every outgoing frame back onto the receive pair. It follows a transmit-active level from the transmit path and the receive carrier-sense level from the carrier detector. Two kinds of fault are counted as a loss of carrier. In the first, carrier sense never comes up while the frame is going out. In the second, carrier comes up and then falls away before the frame has finished.

The verdict is not issued when the fault happens. It is held until transmit-active has gone low. The block then emits a single-cycle write strobe and a 16-bit status word. That word copies an incoming status value, except that the loss-of-carrier flag is placed at bit 11. The descriptor logic that receives the write stores the word in its transmit status entry.

Checking applies only when the attachment port is selected at the start of a frame. For any other frame the flag is written as zero.

Top module: `txlcar_monitor`

## Requirements
- R1: After reset, `stat_wr` is low, and it stays low until a transmission has started and ended.
- R2: If `carrier` is never sampled high at any clock edge after the one that starts the frame, while `tx_active` is still high, the write carries a 1 at bit 11.
- R3: If `carrier` is sampled high and is later sampled low while `tx_active` is still high, the write carries a 1 at bit 11. This holds even if carrier returns before the end of the frame.
- R4: If `carrier` is sampled high and stays high at every later edge until `tx_active` is sampled low, the write carries a 0 at bit 11.
- R5: `stat_wr` is high for exactly one cycle. That cycle comes right after the first clock edge at which `tx_active` is sampled low. No write occurs while the frame is going out.
- R6: `port_sel` is sampled at the edge that starts a frame. If it is low there, bit 11 of that frame's write is 0, whatever the carrier did.
- R7: Every bit of `stat_out` other than bit 11 equals the same bit of `stat_in` in the same cycle.
- R8: A carrier drop that is first seen at the same edge where `tx_active` is sampled low is not a fault.
- R9: A fault recorded for one frame is cleared when the next frame starts. That next frame is judged only on its own carrier.
- R10: Carrier that first rises at or after the edge where `tx_active` is sampled low does not count as seen. The frame is reported as a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 1 | Attachment port selected; enables checking for the frame that starts |
| tx_active | input | 1 | High while a frame is being transmitted |
| carrier | input | 1 | Receive carrier sense from the loopback path |
| stat_in | input | 16 | Status value whose other bits pass through |
| stat_wr | output | 1 | One-cycle write strobe for the status word |
| stat_out | output | 16 | Status word with the loss-of-carrier flag at bit 11 |

## Verification
The bench runs frames with four kinds of carrier: silent throughout, rising late and then held, dropping and then returning, and rising only after the frame has ended. Comparing these separates a missing carrier from an interrupted one, and a genuine echo from carrier that arrives too late. Two frame endings are also paired: one where carrier falls on the same edge that transmit-active falls, and one where carrier stays up past the end. This shows that the end of the frame takes priority over a drop. A deselected-port frame and a clean frame that follows a faulty one show that the enable is latched per frame and that the sticky fault clears at the next start.

// File: rtl/lcar_pkg.sv
package lcar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SEEN   = 2'd2,
    ST_REPORT = 2'd3
  } lcar_state_e;

  // The flag reaches the status word only when checking was enabled.
  function automatic logic reported_flag(input logic fault, input logic en);
    return fault & en;
  endfunction

endpackage

// File: rtl/lcar_seq.sv
module lcar_seq
  import lcar_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_active,
  input  logic        carrier,
  output lcar_state_e state,
  output logic        start_evt,
  output logic        miss_evt,
  output logic        drop_evt,
  output logic        report
);

  lcar_state_e nxt;

  // Events are decoded from the current state and the sampled inputs.
  // End of frame is tested before any carrier drop.
  assign start_evt = (state == ST_IDLE) && tx_active;
  assign miss_evt  = (state == ST_WAIT) && !tx_active;
  assign drop_evt  = (state == ST_SEEN) && tx_active && !carrier;
  assign report    = (state == ST_REPORT);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (tx_active) nxt = ST_WAIT;
      ST_WAIT: begin
        if (!tx_active)   nxt = ST_REPORT;
        else if (carrier) nxt = ST_SEEN;
      end
      ST_SEEN:   if (!tx_active) nxt = ST_REPORT;
      ST_REPORT: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/lcar_fault.sv
module lcar_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic miss_evt,
  input  logic drop_evt,
  input  logic port_sel,
  output logic fault_q,
  output logic en_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      en_q    <= 1'b0;
    end else if (start_evt) begin
      fault_q <= 1'b0;
      en_q    <= port_sel;
    end else if (miss_evt || drop_evt) begin
      fault_q <= 1'b1;
    end
  end

endmodule

// File: rtl/lcar_word.sv
module lcar_word #(
  parameter int WORD_W   = 16,
  parameter int FLAG_BIT = 11
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic              flag,
  output logic [WORD_W-1:0] word_out
);

  localparam logic [WORD_W-1:0] FLAG_MASK = WORD_W'(1) << FLAG_BIT;

  function automatic logic [WORD_W-1:0] insert_flag(
    input logic [WORD_W-1:0] w,
    input logic              f
  );
    return (w & ~FLAG_MASK) | (f ? FLAG_MASK : '0);
  endfunction

  assign word_out = insert_flag(word_in, flag);

endmodule

// File: rtl/txlcar_monitor.sv
module txlcar_monitor
  import lcar_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int FLAG_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_sel,
  input  logic              tx_active,
  input  logic              carrier,
  input  logic [WORD_W-1:0] stat_in,
  output logic              stat_wr,
  output logic [WORD_W-1:0] stat_out
);

  lcar_state_e state;
  logic start_evt, miss_evt, drop_evt, report;
  logic fault_q, en_q, flag;

  lcar_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .carrier   (carrier),
    .state     (state),
    .start_evt (start_evt),
    .miss_evt  (miss_evt),
    .drop_evt  (drop_evt),
    .report    (report)
  );

  lcar_fault u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .miss_evt  (miss_evt),
    .drop_evt  (drop_evt),
    .port_sel  (port_sel),
    .fault_q   (fault_q),
    .en_q      (en_q)
  );

  assign flag = reported_flag(fault_q, en_q);

  lcar_word #(.WORD_W(WORD_W), .FLAG_BIT(FLAG_BIT)) u_word (
    .word_in  (stat_in),
    .flag     (flag),
    .word_out (stat_out)
  );

  assign stat_wr = report;

endmodule

// File: rtl/lcar_checker.sv
module lcar_checker
  import lcar_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int FLAG_BIT = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_active,
  input logic              carrier,
  input logic [WORD_W-1:0] stat_in,
  input logic              stat_wr,
  input logic [WORD_W-1:0] stat_out,
  input lcar_state_e       state,
  input logic              start_evt,
  input logic              fault_q,
  input logic              en_q
);

  localparam logic [WORD_W-1:0] KEEP = ~(WORD_W'(1) << FLAG_BIT);

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> !stat_wr);

  a_r5_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> !$past(tx_active));

  a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_out & KEEP) == (stat_in & KEEP));

  a_r2_miss_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !tx_active) |=> (stat_wr && stat_out[FLAG_BIT] == en_q));

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !start_evt) |=> fault_q);

  a_r3_drop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEEN && tx_active && !carrier) |=> fault_q);

  a_r6_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !en_q) |-> !stat_out[FLAG_BIT]);

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !fault_q);

endmodule

bind txlcar_monitor lcar_checker #(.WORD_W(WORD_W), .FLAG_BIT(FLAG_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_active (tx_active),
  .carrier   (carrier),
  .stat_in   (stat_in),
  .stat_wr   (stat_wr),
  .stat_out  (stat_out),
  .state     (state),
  .start_evt (start_evt),
  .fault_q   (fault_q),
  .en_q      (en_q)
);

// File: tb/sim_txlcar_monitor.sv
module sim_txlcar_monitor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_sel = 1'b0;
  logic        tx_active = 1'b0;
  logic        carrier = 1'b0;
  logic [15:0] stat_in = 16'h0;
  logic        stat_wr;
  logic [15:0] stat_out;

  int vectors = 0;
  int misses  = 0;
  int wr_seen = 0;
  logic last_flag = 1'b0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  txlcar_monitor u0 (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .tx_active(tx_active),
    .carrier(carrier), .stat_in(stat_in), .stat_wr(stat_wr), .stat_out(stat_out)
  );

  // Behavioural reference: frame bookkeeping with plain bits.
  bit m_busy, m_seen, m_bad, m_pending, m_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_seen = 0; m_bad = 0; m_pending = 0; m_en = 0;
    end else if (m_pending) begin
      m_pending = 0;
    end else if (!m_busy) begin
      if (tx_active) begin
        m_busy = 1; m_seen = 0; m_bad = 0; m_en = port_sel;
      end
    end else if (!tx_active) begin
      m_busy = 0; m_pending = 1;
      if (!m_seen) m_bad = 1;
    end else if (carrier) begin
      m_seen = 1;
    end else if (m_seen) begin
      m_bad = 1;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5", {15'b0, stat_wr}, {15'b0, m_pending});
      check("R7", stat_out & 16'hF7FF, stat_in & 16'hF7FF);
      if (m_pending)
        check(cur_req, {15'b0, stat_out[11]}, {15'b0, m_bad & m_en});
      if (stat_wr) begin
        wr_seen++;
        last_flag = stat_out[11];
      end
      stat_in <= 16'($urandom);
    end
  end

  // Frame: cpat bit i is carrier during frame cycle i; tail_car after end.
  task automatic frame(input logic sel, input int len, input logic [31:0] cpat,
                       input logic tail_car, input logic exp_flag, input string req);
    int w0;
    cur_req = req;
    @(negedge clk);
    w0 = wr_seen;
    port_sel = sel;
    for (int i = 0; i < len; i++) begin
      tx_active = 1'b1;
      carrier = cpat[i];
      @(negedge clk);
    end
    check("R5", 16'(wr_seen - w0), 16'd0);
    tx_active = 1'b0;
    carrier = tail_car;
    repeat (4) @(negedge clk);
    carrier = 1'b0;
    check("R5", 16'(wr_seen - w0), 16'd1);
    check(req, {15'b0, last_flag}, {15'b0, exp_flag});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {15'b0, stat_wr}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {15'b0, stat_wr}, 16'd0);

    frame(1'b1, 8, 32'h00, 1'b0, 1'b1, "R2");   // carrier never up
    frame(1'b1, 8, 32'hFC, 1'b1, 1'b0, "R4");   // late rise, held past end
    frame(1'b1, 8, 32'hEE, 1'b1, 1'b1, "R3");   // drop then return
    frame(1'b1, 8, 32'hFE, 1'b0, 1'b0, "R8");   // drop on the ending edge
    frame(1'b0, 8, 32'h00, 1'b0, 1'b0, "R6");   // port not selected
    frame(1'b1, 6, 32'h00, 1'b0, 1'b1, "R2");   // fault again
    frame(1'b1, 6, 32'h3E, 1'b0, 1'b0, "R9");   // clean after a fault
    frame(1'b1, 5, 32'h00, 1'b1, 1'b1, "R10");  // carrier only after end
    frame(1'b0, 5, 32'h1E, 1'b0, 1'b0, "R6");   // deselected, clean
    frame(1'b1, 2, 32'h02, 1'b0, 1'b0, "R4");   // shortest frame with carrier
    frame(1'b1, 1, 32'h01, 1'b1, 1'b1, "R10");  // one-cycle frame

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      misses++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule